// File: doc/BRIEF.md
# Base-and-Limit Address Relocation Unit

This block sits between a requester that issues process-relative logical addresses and the memory system that expects physical addresses. Each accepted request is relocated by adding a programmable partition start (the base) to the logical address. The access is also checked against a programmable partition length (the limit). A request that lands outside the partition, or whose relocated address would not fit the physical address width, returns a protection fault and no translation.

The base and limit are loaded through a small write port. A write takes effect only when the requester is in privileged mode. A write attempted in user mode leaves both registers untouched and raises a one-cycle privilege-violation pulse. Both registers clear on reset, so every access faults until software programs a partition.

Translation is one pipelined register stage. A request presented in cycle N produces its result in cycle N+1.

Top module: `reloc_unit`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and `priv_viol` are 0 and `rsp_paddr` is 0. Base and limit are both 0, so the first request faults.
- R2: A request with `req_valid`=1 in cycle N that passes the checks gives `rsp_valid`=1 in cycle N+1, with `rsp_paddr` = base + `req_laddr`.
- R3: A request whose logical address is greater than or equal to the limit gives `rsp_fault`=1 and `rsp_valid`=0 in cycle N+1. An address equal to the limit faults; limit-1 is accepted.
- R4: A request whose base + logical address does not fit in PA_W bits gives `rsp_fault`=1 and `rsp_valid`=0 in cycle N+1, even when it is inside the limit.
- R5: `rsp_valid` and `rsp_fault` are never both 1. Both are 0 in a cycle that follows a cycle with `req_valid`=0.
- R6: With `priv_mode`=1, `cfg_we`=1 loads `cfg_wdata` into the base when `cfg_sel`=0 and into the limit when `cfg_sel`=1. A request in the same cycle as the write still uses the old value. Requests from the next cycle on use the new value.
- R7: With `priv_mode`=0, a `cfg_we`=1 write changes neither register, and `priv_viol` is 1 for exactly the following cycle. `priv_viol` is 0 in every other cycle.
- R8: `rsp_paddr` is 0 in every cycle in which `rsp_valid` is 0.
- R9: With base 0x09000 and limit 0x02000, logical address 0x1204 translates to physical address 0x0A204.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| req_valid | input | 1 | Logical address request strobe |
| req_laddr | input | LA_W | Logical address |
| priv_mode | input | 1 | 1 = privileged mode, 0 = user mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 = base, 1 = limit |
| cfg_wdata | input | PA_W | Write data |
| rsp_valid | output | 1 | Translation valid |
| rsp_paddr | output | PA_W | Physical address, 0 when not valid |
| rsp_fault | output | 1 | Protection fault for the request of the previous cycle |
| priv_viol | output | 1 | Pulse after a user-mode register write attempt |

## Verification
A corrupted base register appears as a wrong `rsp_paddr` on the first accepted request after the fault. A corrupted limit register flips `rsp_valid` and `rsp_fault` for addresses near the boundary. Either shows one cycle after the offending request. The bench therefore compares every cycle against a model of both registers. It probes the boundary at limit-1, at the limit, and at the physical carry-out, and it checks the same-cycle write ordering. A user-mode write that leaked into a register would show on the next translation, and the bench issues that translation right after each blocked write.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  // Target of a configuration write
  typedef enum logic {
    CFG_BASE  = 1'b0,
    CFG_LIMIT = 1'b1
  } cfg_sel_e;

  // Outcome of one translation attempt
  typedef enum logic [1:0] {
    XL_IDLE  = 2'b00,
    XL_OK    = 2'b01,
    XL_FAULT = 2'b10
  } xl_status_e;

endpackage

// File: rtl/reloc_rst_sync.sv
module reloc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs
  import reloc_pkg::*;
#(
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv_mode,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  output logic [PA_W-1:0] base_q,
  output logic [PA_W-1:0] limit_q,
  output logic            viol_q
);

  cfg_sel_e        sel;
  logic            base_en;
  logic            limit_en;
  logic [PA_W-1:0] base_d;
  logic [PA_W-1:0] limit_d;
  logic            viol_d;

  always_comb begin
    sel      = cfg_sel_e'(cfg_sel);
    base_en  = cfg_we && priv_mode && (sel == CFG_BASE);
    limit_en = cfg_we && priv_mode && (sel == CFG_LIMIT);
    base_d   = base_en  ? cfg_wdata : base_q;
    limit_d  = limit_en ? cfg_wdata : limit_q;
    viol_d   = cfg_we && !priv_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      base_q  <= base_d;
      limit_q <= limit_d;
      viol_q  <= viol_d;
    end
  end

  // R7: a user-mode write leaves both registers unchanged
  p_user_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv_mode) |=> ($stable(base_q) && $stable(limit_q)));

  // R7: the violation pulse follows a blocked write
  p_viol_after_user_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv_mode) |=> viol_q);

  // R7: no violation pulse without a blocked write
  p_viol_only_on_user_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !priv_mode) |=> !viol_q);

  // R6: a privileged base write lands in the next cycle
  p_priv_base_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && priv_mode && !cfg_sel) |=> (base_q == $past(cfg_wdata)));

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
  import reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [LA_W-1:0] req_laddr,
  input  logic [PA_W-1:0] base,
  input  logic [PA_W-1:0] limit,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr
);

  localparam int SUM_W = PA_W + 1;

  logic [PA_W-1:0]  laddr_ext;
  logic [SUM_W-1:0] sum;
  logic             in_bounds;
  logic             no_carry;
  xl_status_e       status;
  logic             valid_d;
  logic             fault_d;
  logic [PA_W-1:0]  paddr_d;
  logic             upd_en;

  always_comb begin
    laddr_ext = {{(PA_W-LA_W){1'b0}}, req_laddr};
    sum       = {1'b0, base} + {1'b0, laddr_ext};
    in_bounds = laddr_ext < limit;
    no_carry  = !sum[SUM_W-1];
    if (!req_valid) begin
      status = XL_IDLE;
    end else if (in_bounds && no_carry) begin
      status = XL_OK;
    end else begin
      status = XL_FAULT;
    end
    valid_d = (status == XL_OK);
    fault_d = (status == XL_FAULT);
    paddr_d = valid_d ? sum[PA_W-1:0] : '0;
    upd_en  = req_valid || rsp_valid || rsp_fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else if (upd_en) begin
      rsp_valid <= valid_d;
      rsp_fault <= fault_d;
      rsp_paddr <= paddr_d;
    end
  end

  // R5: valid and fault never together
  p_valid_fault_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && rsp_fault));

  // R5: nothing emerges after an idle cycle
  p_idle_gives_nothing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault));

  // R8: physical address is zero whenever no translation is valid
  p_paddr_zero_when_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_paddr == '0));

  // R3: an out-of-partition request faults in the next cycle
  p_limit_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ({{(PA_W-LA_W){1'b0}}, req_laddr} >= limit)) |=> (rsp_fault && !rsp_valid));

  // R2: a request always yields exactly one outcome one cycle later
  p_request_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $countones({rsp_valid, rsp_fault}) == 1);

endmodule

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [LA_W-1:0] req_laddr,
  input  logic            priv_mode,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_fault,
  output logic            priv_viol
);

  logic            rst_n_int;
  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] limit_q;

  initial begin
    if (PA_W < LA_W) $error("PA_W must be at least LA_W");
  end

  reloc_rst_sync #(
    .STAGES(2)
  ) i_rst_sync (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_int)
  );

  reloc_cfg_regs #(
    .PA_W(PA_W)
  ) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .priv_mode(priv_mode),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .base_q   (base_q),
    .limit_q  (limit_q),
    .viol_q   (priv_viol)
  );

  reloc_xlate #(
    .LA_W(LA_W),
    .PA_W(PA_W)
  ) i_xlate (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req_valid(req_valid),
    .req_laddr(req_laddr),
    .base     (base_q),
    .limit    (limit_q),
    .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );

  // R1: outputs idle while the internal reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_int |=> (!rsp_valid && !rsp_fault && !priv_viol) || !rst_n_int);

endmodule

// File: tb/test_reloc_unit.sv
module test_reloc_unit;

  localparam int LA_W = 16;
  localparam int PA_W = 20;
  localparam longint PA_SPAN = 64'd1 << PA_W;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic [LA_W-1:0] req_laddr;
  logic            priv_mode;
  logic            cfg_we;
  logic            cfg_sel;
  logic [PA_W-1:0] cfg_wdata;
  logic            rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic            rsp_fault;
  logic            priv_viol;

  int     checks;
  int     failures;
  longint base_m;
  longint limit_m;

  reloc_unit #(
    .LA_W(LA_W),
    .PA_W(PA_W)
  ) i_reloc_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_laddr(req_laddr),
    .priv_mode(priv_mode),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault),
    .priv_viol(priv_viol)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive, update the model, then compare after the edge
  task automatic cycle(input string tag, input logic v, input longint la, input logic priv,
                       input logic we, input logic sel, input longint wd);
    longint sum;
    logic   e_valid;
    logic   e_fault;
    longint e_paddr;
    logic   e_viol;
    req_valid = v;
    req_laddr = LA_W'(la);
    priv_mode = priv;
    cfg_we    = we;
    cfg_sel   = sel;
    cfg_wdata = PA_W'(wd);
    sum     = base_m + la;
    e_valid = v && (la < limit_m) && (sum < PA_SPAN);
    e_fault = v && !e_valid;
    e_paddr = e_valid ? sum : 0;
    e_viol  = we && !priv;
    if (we && priv) begin
      if (sel) limit_m = wd;
      else     base_m  = wd;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "rsp_valid", rsp_valid, e_valid);
    check(tag, "rsp_fault", rsp_fault, e_fault);
    check(tag, "rsp_paddr", rsp_paddr, e_paddr);
    check("R7", "priv_viol", priv_viol, e_viol);
  endtask

  task automatic req(input string tag, input longint la);
    cycle(tag, 1'b1, la, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic idle(input string tag);
    cycle(tag, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic wr(input string tag, input logic priv, input logic sel, input longint wd);
    cycle(tag, 1'b0, 0, priv, 1'b1, sel, wd);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0;
    base_m = 0; limit_m = 0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_laddr = '0; priv_mode = 1'b0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    check("R1", "rsp_valid", rsp_valid, 0);
    check("R1", "rsp_fault", rsp_fault, 0);
    check("R1", "rsp_paddr", rsp_paddr, 0);
    check("R1", "priv_viol", priv_viol, 0);
    rst_n = 1'b1;
    repeat (3) idle("R1");
    // R1: unprogrammed registers fault every access
    req("R1", 0);
    req("R1", 16'h0040);
    // R7: user writes blocked; following requests prove registers unchanged
    wr("R7", 1'b0, 1'b1, 20'h02000);
    req("R7", 16'h0010);
    wr("R6", 1'b1, 1'b1, 20'h02000);
    wr("R7", 1'b0, 1'b0, 20'h09000);
    req("R7", 16'h0010);
    // R6: base write with a same-cycle request uses the old base
    cycle("R6", 1'b1, 16'h0010, 1'b1, 1'b1, 1'b0, 20'h09000);
    req("R6", 16'h0010);
    // R9: worked example
    req("R9", 16'h1204);
    // R3: boundary around the limit
    req("R3", 16'h1FFF);
    req("R3", 16'h2000);
    req("R3", 16'hFFFF);
    // R5 / R8: idle after traffic
    idle("R5");
    idle("R8");
    // R4: physical carry-out
    wr("R6", 1'b1, 1'b0, 20'hFFF00);
    wr("R6", 1'b1, 1'b1, 20'hFFFFF);
    req("R4", 16'h00FF);
    req("R4", 16'h0100);
    req("R4", 16'h0000);
    // R2: streaming with a mix of in- and out-of-range addresses
    wr("R6", 1'b1, 1'b0, 20'h12340);
    wr("R6", 1'b1, 1'b1, 20'h08000);
    for (int i = 0; i < 64; i++) begin
      longint la;
      la = (i * 1237 + 91) % 65536;
      if (i % 5 == 4) idle("R5");
      else            req("R2", la);
    end
    // R6: limit write with same-cycle request uses old limit
    cycle("R6", 1'b1, 16'h7000, 1'b1, 1'b1, 1'b1, 20'h06000);
    req("R6", 16'h7000);
    // R7: user write alongside a request
    cycle("R7", 1'b1, 16'h0100, 1'b0, 1'b1, 1'b0, 20'h00000);
    req("R7", 16'h0100);
    idle("R8");
    finish_run();
  end

endmodule